// File: doc/BRIEF.md
# Framed Register-Access Controller

This block is a small slave that serves one request at a time. Requests arrive as byte-wide frames on an input stream with a valid/accept handshake and start and stop markers. The first byte of a frame is a header. Its low nibble selects the operation and its high nibble names one of eight 8-bit internal registers. A read frame is one byte. A write frame is a header followed by one data byte.

When the request has been handled, the block returns an acknowledge frame on an output stream with the same kind of handshake and markers. The acknowledge frame carries a copy of the header, then the register value for reads, then a footer byte whose value is the error flag. An address outside the register range is reported through that flag. Requests that are malformed, and writes whose data byte lacks a stop marker, are consumed silently and get no acknowledge. Each acknowledge beat is followed by one idle cycle on the output, and every beat holds steady under backpressure.

The asynchronous active-low reset is released through a two-stage synchronizer. The first header is therefore accepted three clocks after the reset input rises.

Top module: `regacc_ctrl`

## Requirements
- R1: While reset is asserted, `out_valid` and `in_accept` are 0, and every register reads back as 0x00 after reset.
- R2: After reset release, or after a frame ends, the block waits one idle cycle and then raises `in_accept` to take a header. `in_accept` is high only while the block waits for a header or for a write data byte, and is never high while `out_valid` is high.
- R3: Header layout: bits [3:0] are the opcode (read = 4'h1, write = 4'h2) and bits [7:4] are the register address. A read request is one accepted byte with start=1, stop=1 and the read opcode. A write header has start=1, stop=0 and the write opcode.
- R4: A read is acknowledged with three beats: the header echo with start=1, then the register value with start=0 and stop=0, then a footer with stop=1 and data 0x00 (no error) or 0x01 (error). A later frame starts again with its error flag clear.
- R5: A write data byte accepted with stop=1 updates the addressed register. The write is acknowledged with two beats: the header echo with start=1, then the footer with stop=1.
- R6: An address of 8 or more sets the footer to 0x01. A read of such an address returns data 0x00, and a write to it changes no register.
- R7: A write data byte accepted with stop=0 is discarded. No register changes and no acknowledge is sent.
- R8: A start-marked header with any opcode other than 4'h1 or 4'h2 is consumed with no acknowledge. So is a read opcode with stop=0, and so is a write opcode with stop=1.
- R9: The first acknowledge beat appears three cycles after a read header is accepted, and two cycles after a write data byte is accepted. After each accepted beat, `out_valid` is low for exactly one cycle before the next beat.
- R10: While `out_valid` is high and `out_accept` is low, `out_valid`, `out_start`, `out_stop` and `out_data` hold their values.
- R11: `out_start` and `out_stop` are never high together, and neither is high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request byte valid |
| in_start | input | 1 | Request byte is the first of its frame |
| in_stop | input | 1 | Request byte is the last of its frame |
| in_data | input | 8 | Request byte |
| in_accept | output | 1 | Block takes the request byte this cycle |
| out_valid | output | 1 | Acknowledge beat valid |
| out_start | output | 1 | Beat is the header echo |
| out_stop | output | 1 | Beat is the footer |
| out_data | output | 8 | Acknowledge byte |
| out_accept | input | 1 | Receiver takes the acknowledge beat |

## Verification
The bench targets the reads and writes at addresses 8 to 15. A design that wrapped the address would corrupt a real register, or would return its contents with a clear footer. Writes without a stop marker and the three malformed header shapes are each followed by a read-back and a count of acknowledge beats. These catch a design that writes on any data byte or that acknowledges junk. The bench also checks that a read after an error frame shows a clear footer. Periodic backpressure, together with a cycle-by-cycle comparison of `out_valid`, exposes a missing or doubled idle cycle between beats and any beat that changes while it is stalled.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_GET_HDR   = 3'd1,
    ST_GET_DATA  = 3'd2,
    ST_SET_DATA  = 3'd3,
    ST_SEND_HDR  = 3'd4,
    ST_SEND_DATA = 3'd5,
    ST_SEND_FTR  = 3'd6
  } state_e;

  localparam logic [3:0] OPC_READ  = 4'h1;
  localparam logic [3:0] OPC_WRITE = 4'h2;
endpackage

// File: rtl/regacc_rst_sync.sv
module regacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shreg <= '0;
    else           shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shreg[STAGES-1];
endmodule

// File: rtl/regacc_hdr_dec.sv
module regacc_hdr_dec #(
  parameter int DW    = 8,
  parameter int NREGS = 8
) (
  input  logic [DW-1:0]   hdr,
  output logic            is_read,
  output logic            is_write,
  output logic [DW/2-1:0] addr,
  output logic            addr_ok
);
  import regacc_pkg::*;
  localparam int OPW = DW / 2;

  always_comb begin
    is_read  = (hdr[OPW-1:0] == OPW'(OPC_READ));
    is_write = (hdr[OPW-1:0] == OPW'(OPC_WRITE));
    addr     = hdr[DW-1:OPW];
    addr_ok  = (32'(addr) < 32'(NREGS));
  end
endmodule

// File: rtl/regacc_regfile.sv
module regacc_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [NREGS-1:0][DW-1:0] regs;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    assign en = we && (32'(addr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign regs[g] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (32'(addr) == i) rdata = regs[i];
    end
  end
endmodule

// File: rtl/regacc_fsm.sv
module regacc_fsm #(
  parameter int DW    = 8,
  parameter int NREGS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_start,
  input  logic            in_stop,
  input  logic [DW-1:0]   in_data,
  output logic            in_accept,
  input  logic            out_accept,
  output logic            out_valid,
  output logic            out_start,
  output logic            out_stop,
  output logic [DW-1:0]   out_data,
  output logic            reg_we,
  output logic [DW/2-1:0] reg_addr,
  output logic [DW-1:0]   reg_wdata,
  input  logic [DW-1:0]   reg_rdata,
  output logic [2:0]      state_o,
  output logic            err_o
);
  import regacc_pkg::*;
  localparam int AW = DW / 2;

  state_e        state_q, state_d;
  logic [DW-1:0] hdr_q;
  logic [DW-1:0] data_q, data_d;
  logic          err_q, err_d, err_en;
  logic          ovld_q, ovld_d;
  logic          hdr_en, data_en;
  logic          sending, beat_done;
  logic [DW-1:0] dec_in;
  logic          dec_rd, dec_wr, dec_ok;
  logic [AW-1:0] dec_addr;

  // The decoder looks at the incoming byte while a header is awaited,
  // and at the held header otherwise.
  assign dec_in = (state_q == ST_GET_HDR) ? in_data : hdr_q;

  regacc_hdr_dec #(.DW(DW), .NREGS(NREGS)) u_dec (
    .hdr      (dec_in),
    .is_read  (dec_rd),
    .is_write (dec_wr),
    .addr     (dec_addr),
    .addr_ok  (dec_ok)
  );

  assign in_accept = (state_q == ST_GET_HDR) || (state_q == ST_SET_DATA);
  assign sending   = (state_q == ST_SEND_HDR) || (state_q == ST_SEND_DATA) ||
                     (state_q == ST_SEND_FTR);
  assign beat_done = ovld_q && out_accept;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     state_d = ST_GET_HDR;
      ST_GET_HDR: begin
        if (in_valid && in_start) begin
          if (dec_rd && in_stop)       state_d = ST_GET_DATA;
          else if (dec_wr && !in_stop) state_d = ST_SET_DATA;
          else                         state_d = ST_IDLE;
        end
      end
      ST_GET_DATA: state_d = ST_SEND_HDR;
      ST_SET_DATA: begin
        if (in_valid) state_d = in_stop ? ST_SEND_HDR : ST_IDLE;
      end
      ST_SEND_HDR: begin
        if (beat_done) state_d = dec_rd ? ST_SEND_DATA : ST_SEND_FTR;
      end
      ST_SEND_DATA: begin
        if (beat_done) state_d = ST_SEND_FTR;
      end
      ST_SEND_FTR: begin
        if (beat_done) state_d = ST_IDLE;
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    hdr_en    = (state_q == ST_GET_HDR) && in_valid && in_start;
    reg_we    = (state_q == ST_SET_DATA) && in_valid && in_stop && dec_ok;
    reg_addr  = dec_addr;
    reg_wdata = in_data;
    data_en   = (state_q == ST_GET_DATA);
    data_d    = dec_ok ? reg_rdata : '0;
    err_en    = 1'b0;
    err_d     = err_q;
    if ((state_q == ST_GET_DATA) ||
        ((state_q == ST_SET_DATA) && in_valid && in_stop)) begin
      err_en = 1'b1;
      err_d  = !dec_ok;
    end else if ((state_q == ST_SEND_FTR) && beat_done) begin
      err_en = 1'b1;
      err_d  = 1'b0;
    end
    // Present a beat when none is up; drop it for one cycle once taken.
    ovld_d = sending && !beat_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      ovld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ovld_q  <= ovld_d;
      if (hdr_en)  hdr_q  <= in_data;
      if (data_en) data_q <= data_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  always_comb begin
    out_valid = ovld_q;
    out_start = ovld_q && (state_q == ST_SEND_HDR);
    out_stop  = ovld_q && (state_q == ST_SEND_FTR);
    out_data  = '0;
    if (ovld_q) begin
      unique case (state_q)
        ST_SEND_HDR:  out_data = hdr_q;
        ST_SEND_DATA: out_data = data_q;
        default:      out_data = {{(DW-1){1'b0}}, err_q};
      endcase
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
endmodule

// File: rtl/regacc_ctrl.sv
module regacc_ctrl #(
  parameter int DW    = 8,
  parameter int NREGS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_stop,
  input  logic [DW-1:0] in_data,
  output logic          in_accept,
  output logic          out_valid,
  output logic          out_start,
  output logic          out_stop,
  output logic [DW-1:0] out_data,
  input  logic          out_accept
);
  localparam int AW = DW / 2;

  logic          rst_n_sync;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [2:0]    fsm_state;
  logic          fsm_err;

  regacc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  regacc_regfile #(.DW(DW), .NREGS(NREGS), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata)
  );

  regacc_fsm #(.DW(DW), .NREGS(NREGS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_stop    (in_stop),
    .in_data    (in_data),
    .in_accept  (in_accept),
    .out_accept (out_accept),
    .out_valid  (out_valid),
    .out_start  (out_start),
    .out_stop   (out_stop),
    .out_data   (out_data),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .state_o    (fsm_state),
    .err_o      (fsm_err)
  );
endmodule

// File: rtl/regacc_ctrl_chk.sv
module regacc_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_accept,
  input logic          out_valid,
  input logic          out_start,
  input logic          out_stop,
  input logic [DW-1:0] out_data,
  input logic          out_accept,
  input logic [2:0]    fsm_state,
  input logic          fsm_err
);
  AST_MARKERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_start && out_stop)); // R11
  AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_start || out_stop) |-> out_valid); // R11
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |=> (out_valid && $stable(out_data) &&
                                    $stable(out_start) && $stable(out_stop))); // R10
  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_accept) |=> !out_valid); // R9
  AST_NO_ACCEPT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_accept); // R2
  AST_FOOTER_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_stop |-> (out_data[DW-1:1] == '0)); // R4
  AST_ERR_CLEAR_IN_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state inside {3'd1, 3'd2, 3'd3}) |-> !fsm_err); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !in_accept)); // R1
endmodule

bind regacc_ctrl regacc_ctrl_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_accept  (in_accept),
  .out_valid  (out_valid),
  .out_start  (out_start),
  .out_stop   (out_stop),
  .out_data   (out_data),
  .out_accept (out_accept),
  .fsm_state  (fsm_state),
  .fsm_err    (fsm_err)
);

// File: tb/regacc_ctrl_tb.sv
`timescale 1ns/1ps
module regacc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_start = 1'b0, in_stop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_accept;
  logic       out_valid, out_start, out_stop;
  logic [7:0] out_data;
  logic       out_accept = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  regacc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_start(in_start), .in_stop(in_stop),
    .in_data(in_data), .in_accept(in_accept),
    .out_valid(out_valid), .out_start(out_start), .out_stop(out_stop),
    .out_data(out_data), .out_accept(out_accept)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed { logic s; logic p; logic [7:0] d; } beat_t;
  beat_t      mq[$];
  logic [7:0] mregs [8];
  int         mphase = 0;   // 0 waiting, 1 header, 2 write data, 3 replying
  int         mwait  = 3;
  int         mgap   = 0;
  logic [7:0] mhdr   = 8'h00;

  function automatic bit m_valid();
    return (mphase == 3) && (mgap == 0) && (mq.size() > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mregs[i] = 8'h00;
      mq.delete();
      mphase = 0; mwait = 3; mgap = 0;
    end else begin
      case (mphase)
        0: begin
          if (mwait > 1) mwait--;
          else mphase = 1;
        end
        1: if (in_valid && in_start) begin
          int a;
          mhdr = in_data;
          a = int'(in_data[7:4]);
          if (in_data[3:0] == 4'h1 && in_stop) begin
            mq.push_back('{1'b1, 1'b0, in_data});
            mq.push_back('{1'b0, 1'b0, (a < 8) ? mregs[a] : 8'h00});
            mq.push_back('{1'b0, 1'b1, {7'd0, a >= 8}});
            mgap = 2; mphase = 3;
          end else if (in_data[3:0] == 4'h2 && !in_stop) begin
            mphase = 2;
          end else begin
            mphase = 0; mwait = 1;
          end
        end
        2: if (in_valid) begin
          int a;
          a = int'(mhdr[7:4]);
          if (in_stop) begin
            if (a < 8) mregs[a] = in_data;
            mq.push_back('{1'b1, 1'b0, mhdr});
            mq.push_back('{1'b0, 1'b1, {7'd0, a >= 8}});
            mgap = 1; mphase = 3;
          end else begin
            mphase = 0; mwait = 1;
          end
        end
        default: begin
          if (m_valid() && out_accept) begin
            void'(mq.pop_front());
            if (mq.size() == 0) begin mphase = 0; mwait = 1; end
            else mgap = 1;
          end else if (mgap > 0) mgap--;
        end
      endcase
    end
  end

  // ---------------- per-cycle comparison and beat monitor ----------------
  int         beat_cnt = 0;
  logic [7:0] last_rd = 8'h00, last_ftr = 8'h00;
  bit         p_valid = 0, p_acc = 0, p_start = 0, p_stop = 0;
  logic [7:0] p_data = 8'h00;

  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      bit ev;
      ev = m_valid();
      chk(in_accept == (mphase == 1 || mphase == 2), "R2", "in_accept",
          int'(in_accept), int'(mphase == 1 || mphase == 2));
      chk(out_valid == ev, "R9", "out_valid", int'(out_valid), int'(ev));
      chk(!(out_start && out_stop), "R11", "start&stop",
          int'({out_start, out_stop}), 0);
      if (p_valid && !p_acc)
        chk(out_valid && out_start == p_start && out_stop == p_stop &&
            out_data == p_data, "R10", "stalled beat",
            int'(out_data), int'(p_data));
      if (p_valid && p_acc)
        chk(!out_valid, "R9", "gap after beat", int'(out_valid), 0);
      if (ev && out_valid) begin
        chk(out_start == mq[0].s && out_stop == mq[0].p, "R4", "markers",
            int'({out_start, out_stop}), int'({mq[0].s, mq[0].p}));
        chk(out_data == mq[0].d, "R4", "beat data", int'(out_data),
            int'(mq[0].d));
      end
      if (out_valid && out_accept) begin
        beat_cnt++;
        if (out_stop) last_ftr = out_data;
        else if (!out_start) last_rd = out_data;
      end
    end
    p_valid = out_valid; p_acc = out_accept;
    p_start = out_start; p_stop = out_stop; p_data = out_data;
  end

  // ---------------- backpressure driver ----------------
  bit bp_on = 0;
  int bp_cnt = 0;
  always @(negedge clk) begin
    bp_cnt++;
    out_accept = bp_on ? (bp_cnt % 3 == 0) : 1'b1;
  end

  // ---------------- stimulus tasks ----------------
  task automatic send_byte(input bit s, input bit p, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_start = s; in_stop = p; in_data = d;
    forever begin
      bit acc;
      acc = in_accept;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0;
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (mphase != 1);
  endtask

  task automatic do_read(input int a, input logic [7:0] exp_d,
                         input logic [7:0] exp_f, input string req);
    int b0;
    b0 = beat_cnt;
    send_byte(1'b1, 1'b1, {4'(a), 4'h1});
    wait_ready();
    chk(beat_cnt - b0 == 3, req, "read beat count", beat_cnt - b0, 3);
    chk(last_rd == exp_d, req, "read data", int'(last_rd), int'(exp_d));
    chk(last_ftr == exp_f, req, "read footer", int'(last_ftr), int'(exp_f));
  endtask

  task automatic do_write(input int a, input logic [7:0] d,
                          input logic [7:0] exp_f, input string req);
    int b0;
    b0 = beat_cnt;
    send_byte(1'b1, 1'b0, {4'(a), 4'h2});
    send_byte(1'b0, 1'b1, d);
    wait_ready();
    chk(beat_cnt - b0 == 2, req, "write beat count", beat_cnt - b0, 2);
    chk(last_ftr == exp_f, req, "write footer", int'(last_ftr), int'(exp_f));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    int b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_accept, "R1", "outputs in reset",
        int'({out_valid, in_accept}), 0);
    rst_n = 1'b1;
    wait_ready();

    do_read(5, 8'h00, 8'h00, "R1");
    do_write(3, 8'hA5, 8'h00, "R5");
    do_read(3, 8'hA5, 8'h00, "R3");
    do_write(7, 8'h3C, 8'h00, "R5");
    do_write(0, 8'h81, 8'h00, "R5");
    do_read(7, 8'h3C, 8'h00, "R5");
    do_read(0, 8'h81, 8'h00, "R5");

    // out-of-range addresses
    do_read(9, 8'h00, 8'h01, "R6");
    do_read(3, 8'hA5, 8'h00, "R4");          // flag clear again
    do_write(12, 8'hFF, 8'h01, "R6");
    do_write(8, 8'hEE, 8'h01, "R6");
    do_read(0, 8'h81, 8'h00, "R6");
    do_read(3, 8'hA5, 8'h00, "R6");
    do_read(4, 8'h00, 8'h00, "R6");
    do_read(7, 8'h3C, 8'h00, "R6");

    // write data without stop is dropped
    b0 = beat_cnt;
    send_byte(1'b1, 1'b0, 8'h32);
    send_byte(1'b0, 1'b0, 8'h55);
    wait_ready();
    chk(beat_cnt == b0, "R7", "no ack on dropped write", beat_cnt - b0, 0);
    do_read(3, 8'hA5, 8'h00, "R7");

    // malformed headers
    b0 = beat_cnt;
    send_byte(1'b1, 1'b1, 8'h33);
    wait_ready();
    send_byte(1'b1, 1'b0, 8'h31);
    wait_ready();
    send_byte(1'b1, 1'b1, 8'h32);
    wait_ready();
    chk(beat_cnt == b0, "R8", "no ack on malformed", beat_cnt - b0, 0);
    do_read(3, 8'hA5, 8'h00, "R8");

    // backpressure
    bp_on = 1;
    do_write(2, 8'h42, 8'h00, "R10");
    do_read(2, 8'h42, 8'h00, "R10");
    do_read(11, 8'h00, 8'h01, "R10");
    do_write(6, 8'h99, 8'h00, "R9");
    bp_on = 0;
    do_read(6, 8'h99, 8'h00, "R9");

    // reset in the middle of a frame, then registers cleared
    send_byte(1'b1, 1'b1, 8'h71);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_valid && !in_accept, "R1", "outputs in mid-frame reset",
        int'({out_valid, in_accept}), 0);
    rst_n = 1'b1;
    wait_ready();
    do_read(7, 8'h00, 8'h00, "R1");
    do_read(2, 8'h00, 8'h00, "R1");

    repeat (4) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule